// File: doc/BRIEF.md
# PFD Digital Lock Detector

This block sits beside the phase-frequency detector of a synthesizer and decides whether the loop is locked. It watches two single-cycle strobes: one marks each reference edge and one marks each feedback-divider edge. It measures how far apart each matching pair of edges lies. The distance is counted in ticks of a fast sampling clock. From that series of measurements it drives a registered, active-high lock flag.

The flag has hysteresis. It sets only after a run of consecutive tight measurements, which are those below the programmable near threshold. It clears as soon as a single measurement reaches the far threshold, or when a pair of edges fails to complete within a timeout. A measurement that falls between the two thresholds restarts the run but leaves an asserted flag untouched. The near threshold plays the role of the small phase window and the far threshold the role of the wider one. Both are given in sampling ticks, so the user scales them to the sampling clock.

Top module: `pfd_lock_detect`

## Requirements
- R1: The lock output is active high. It reads 0 while rst_n is low and directly after reset. Reset also discards any partial run of tight measurements.
- R2: Lock rises on the GOOD_RUN-th (default 5th) consecutive measurement whose error is below tight_thr, and not on any earlier one.
- R3: A measurement starts at whichever strobe arrives first and ends at the first strobe of the other kind. Its error is the number of clock cycles between the two strobes. Strobes sampled in the same cycle give an error of 0.
- R4: A single measurement with error of at least loose_thr clears lock and the run, whatever the earlier history.
- R5: A measurement with error at least tight_thr and below loose_thr restarts the run at zero and leaves lock unchanged.
- R6: If the partner strobe has not arrived TIMEOUT_TICKS cycles after the leading strobe, the measurement ends in that cycle and counts like a far-threshold violation.
- R7: A repeated leading strobe that arrives before the partner is ignored. The error is still counted from the first leading strobe.
- R8: Lock is registered. It changes only in the cycle after a completed measurement and holds steady at all other times.
- R9: The thresholds are strict at the low side. An error equal to tight_thr is not tight, and an error of loose_thr - 1 is in the middle band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; all timing counts in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | One-cycle strobe per reference edge |
| fb_pulse | input | 1 | One-cycle strobe per feedback-divider edge |
| tight_thr | input | CNT_W | Near threshold in ticks; an error below it counts toward lock |
| loose_thr | input | CNT_W | Far threshold in ticks; an error at or above it drops lock |
| lock | output | 1 | Registered lock flag, active high |

## Verification
The bench builds the block with CNT_W = 8, GOOD_RUN = 5 and TIMEOUT_TICKS = 40. It programs the thresholds to 3 and 6 ticks. With thresholds this small, the gaps of 0 to 6 cycles cover every class boundary, including the exact values at each threshold. With a timeout this short, the timeout path can be reached within a few dozen cycles. The run length of 5 keeps the check that lock does not rise early down to four-measurement sequences. Short gaps also let a duplicate leading strobe change which class a measurement falls into, so the ignore rule shows up at the lock output.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_GOOD = 2'd1,
    CLS_MID  = 2'd2,
    CLS_BAD  = 2'd3
  } err_class_e;

  // Sorts one finished measurement into a hysteresis band.
  function automatic err_class_e classify_err(
    input logic        done,
    input logic        timed_out,
    input int unsigned err,
    input int unsigned tight,
    input int unsigned loose
  );
    if (!done)                         return CLS_NONE;
    else if (timed_out || err >= loose) return CLS_BAD;
    else if (err < tight)              return CLS_GOOD;
    else                               return CLS_MID;
  endfunction

  // Saturating step of the tight-run counter.
  function automatic int unsigned run_step(input int unsigned cur, input int unsigned limit);
    return (cur >= limit) ? limit : cur + 1;
  endfunction

endpackage

// File: rtl/pfd_edge_timer.sv
module pfd_edge_timer #(
  parameter int CNT_W         = 8,
  parameter int TIMEOUT_TICKS = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_pulse,
  input  logic             fb_pulse,
  output logic             meas_done,
  output logic             meas_timeout,
  output logic [CNT_W-1:0] meas_err,
  output logic             armed,
  output logic [CNT_W-1:0] tick_cnt
);

  localparam logic [CNT_W-1:0] TO_LIM = CNT_W'(TIMEOUT_TICKS);

  logic             armed_q;
  logic             lead_ref_q;
  logic [CNT_W-1:0] cnt_q;
  logic             partner_hit;
  logic             at_limit;

  assign partner_hit = armed_q & (lead_ref_q ? fb_pulse : ref_pulse);
  assign at_limit    = armed_q & (cnt_q == TO_LIM);

  always_comb begin
    if (!armed_q) begin
      meas_done    = ref_pulse & fb_pulse;
      meas_timeout = 1'b0;
      meas_err     = '0;
    end else begin
      meas_done    = partner_hit | at_limit;
      meas_timeout = at_limit & ~partner_hit;
      meas_err     = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      lead_ref_q <= 1'b0;
      cnt_q      <= '0;
    end else if (!armed_q) begin
      if (ref_pulse ^ fb_pulse) begin
        armed_q    <= 1'b1;
        lead_ref_q <= ref_pulse;
        cnt_q      <= CNT_W'(1);
      end
    end else if (meas_done) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign armed    = armed_q;
  assign tick_cnt = cnt_q;

endmodule

// File: rtl/pfd_lock_judge.sv
module pfd_lock_judge
  import pfd_lock_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int GOOD_RUN = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               meas_done,
  input  logic                               meas_timeout,
  input  logic [CNT_W-1:0]                   meas_err,
  input  logic [CNT_W-1:0]                   tight_thr,
  input  logic [CNT_W-1:0]                   loose_thr,
  output logic                               meas_good,
  output logic                               meas_mid,
  output logic                               meas_bad,
  output logic [$clog2(GOOD_RUN+1)-1:0]      run_cnt,
  output logic                               lock
);

  localparam int RUN_W = $clog2(GOOD_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(GOOD_RUN);

  err_class_e       cls;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_nxt;
  logic             lock_q;

  assign cls = classify_err(meas_done, meas_timeout, 32'(meas_err),
                            32'(tight_thr), 32'(loose_thr));

  assign meas_good = (cls == CLS_GOOD);
  assign meas_mid  = (cls == CLS_MID);
  assign meas_bad  = (cls == CLS_BAD);
  assign run_nxt   = RUN_W'(run_step(32'(run_q), GOOD_RUN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      unique case (cls)
        CLS_GOOD: begin
          run_q <= run_nxt;
          if (run_nxt == RUN_LIM) lock_q <= 1'b1;
        end
        CLS_MID:  run_q <= '0;
        CLS_BAD: begin
          run_q  <= '0;
          lock_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign run_cnt = run_q;
  assign lock    = lock_q;

endmodule

// File: rtl/pfd_lock_detect.sv
module pfd_lock_detect #(
  parameter int CNT_W         = 8,
  parameter int GOOD_RUN      = 5,
  parameter int TIMEOUT_TICKS = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_pulse,
  input  logic             fb_pulse,
  input  logic [CNT_W-1:0] tight_thr,
  input  logic [CNT_W-1:0] loose_thr,
  output logic             lock
);

  localparam int RUN_W = $clog2(GOOD_RUN + 1);

  logic             meas_done;
  logic             meas_timeout;
  logic [CNT_W-1:0] meas_err;
  logic             armed;
  logic [CNT_W-1:0] tick_cnt;
  logic             meas_good;
  logic             meas_mid;
  logic             meas_bad;
  logic [RUN_W-1:0] run_cnt;

  pfd_edge_timer #(
    .CNT_W        (CNT_W),
    .TIMEOUT_TICKS(TIMEOUT_TICKS)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_pulse   (ref_pulse),
    .fb_pulse    (fb_pulse),
    .meas_done   (meas_done),
    .meas_timeout(meas_timeout),
    .meas_err    (meas_err),
    .armed       (armed),
    .tick_cnt    (tick_cnt)
  );

  pfd_lock_judge #(
    .CNT_W   (CNT_W),
    .GOOD_RUN(GOOD_RUN)
  ) u_judge (
    .clk         (clk),
    .rst_n       (rst_n),
    .meas_done   (meas_done),
    .meas_timeout(meas_timeout),
    .meas_err    (meas_err),
    .tight_thr   (tight_thr),
    .loose_thr   (loose_thr),
    .meas_good   (meas_good),
    .meas_mid    (meas_mid),
    .meas_bad    (meas_bad),
    .run_cnt     (run_cnt),
    .lock        (lock)
  );

endmodule

// File: rtl/pfd_lock_detect_chk.sv
module pfd_lock_detect_chk #(
  parameter int CNT_W         = 8,
  parameter int GOOD_RUN      = 5,
  parameter int TIMEOUT_TICKS = 200
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          lock,
  input logic                          meas_done,
  input logic                          meas_timeout,
  input logic                          meas_good,
  input logic                          meas_mid,
  input logic                          meas_bad,
  input logic                          armed,
  input logic [CNT_W-1:0]              tick_cnt,
  input logic [$clog2(GOOD_RUN+1)-1:0] run_cnt
);

  p_bad_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    meas_bad |=> !lock);

  p_fall_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> $past(meas_bad));

  p_mid_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    meas_mid |=> $stable(lock));

  p_quiet_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_done |=> $stable(lock));

  p_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(meas_good));

  p_run_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= ($clog2(GOOD_RUN+1))'(GOOD_RUN));

  p_timer_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (tick_cnt != '0) && (tick_cnt <= CNT_W'(TIMEOUT_TICKS)));

  p_timeout_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    meas_timeout |-> armed && meas_bad);

endmodule

bind pfd_lock_detect pfd_lock_detect_chk #(
  .CNT_W        (CNT_W),
  .GOOD_RUN     (GOOD_RUN),
  .TIMEOUT_TICKS(TIMEOUT_TICKS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lock        (lock),
  .meas_done   (meas_done),
  .meas_timeout(meas_timeout),
  .meas_good   (meas_good),
  .meas_mid    (meas_mid),
  .meas_bad    (meas_bad),
  .armed       (armed),
  .tick_cnt    (tick_cnt),
  .run_cnt     (run_cnt)
);

// File: tb/tb_pfd_lock_detect.sv
module tb_pfd_lock_detect;

  localparam int CNT_W   = 8;
  localparam int RUN     = 5;
  localparam int TO      = 40;
  localparam int TIGHT   = 3;
  localparam int LOOSE   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_pulse = 1'b0;
  logic fb_pulse = 1'b0;
  logic [CNT_W-1:0] tight_thr = CNT_W'(TIGHT);
  logic [CNT_W-1:0] loose_thr = CNT_W'(LOOSE);
  logic lock;

  pfd_lock_detect #(.CNT_W(CNT_W), .GOOD_RUN(RUN), .TIMEOUT_TICKS(TO)) dut (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .tight_thr(tight_thr), .loose_thr(loose_thr), .lock(lock)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int    due;
    logic  exp;
    string tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_vec = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;
  bit m_lock = 1'b0;
  int m_run = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // bench model of the hysteresis rules
  task automatic model_apply(input int err, input bit to);
    if (to || err >= LOOSE) begin
      m_lock = 1'b0; m_run = 0;
    end else if (err < TIGHT) begin
      if (m_run < RUN) m_run = m_run + 1;
      if (m_run == RUN) m_lock = 1'b1;
    end else begin
      m_run = 0;
    end
  endtask

  task automatic step(input bit r, input bit f, input bit ev, input int err,
                      input bit to, input string tag);
    item_t it;
    @(negedge clk);
    ref_pulse = r;
    fb_pulse  = f;
    if (ev) model_apply(err, to);
    it.due = cyc + 1;
    it.exp = m_lock;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic meas(input bit ref_first, input int gap, input int dup_at,
                      input int err, input string tag);
    if (gap == 0) begin
      step(1'b1, 1'b1, 1'b1, err, 1'b0, tag);
    end else begin
      step(ref_first, !ref_first, 1'b0, 0, 1'b0, tag);
      for (int i = 1; i < gap; i++) begin
        if (i == dup_at) step(ref_first, !ref_first, 1'b0, 0, 1'b0, tag);
        else             step(1'b0, 1'b0, 1'b0, 0, 1'b0, tag);
      end
      step(!ref_first, ref_first, 1'b1, err, 1'b0, tag);
    end
    step(1'b0, 1'b0, 1'b0, 0, 1'b0, tag);
  endtask

  task automatic timeout_meas(input bit ref_first, input string tag);
    step(ref_first, !ref_first, 1'b0, 0, 1'b0, tag);
    for (int i = 1; i < TO; i++) step(1'b0, 1'b0, 1'b0, 0, 1'b0, tag);
    step(1'b0, 1'b0, 1'b1, 0, 1'b1, tag);
    step(1'b0, 1'b0, 1'b0, 0, 1'b0, tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    ref_pulse = 1'b0;
    fb_pulse  = 1'b0;
    rst_n     = 1'b0;
    q.delete();
    m_lock = 1'b0;
    m_run  = 0;
    #1;
    n_vec++;
    if (lock !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: lock during reset act=%b exp=0", tag, lock);
    end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor: pops expectations as their cycle comes due
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        it = q.pop_front();
        n_vec++;
        if (it.due != cyc || lock !== it.exp) begin
          n_bad++;
          $display("FAIL %s: cycle %0d lock act=%b exp=%b", it.tag, cyc, lock, it.exp);
        end
      end
    end
  end

  initial begin
    #(20000 * 5);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog: run hung act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset("R1 reset state");
    step(1'b0, 1'b0, 1'b0, 0, 1'b0, "R1 idle after reset");

    // R2: four tight do not lock, the fifth does (gap 1, ref leads)
    for (int k = 0; k < 4; k++) meas(1'b1, 1, 0, 1, "R2 no early lock");
    meas(1'b1, 1, 0, 1, "R2 fifth tight locks");

    // R5: middle band keeps lock
    meas(1'b0, 4, 0, 4, "R5 mid keeps lock");
    // R9 / R4: error equal to loose drops lock
    meas(1'b1, 6, 0, 6, "R4 R9 error at loose drops");

    // R3: feedback leading, gap 2, then R9 error equal tight restarts run
    for (int k = 0; k < 3; k++) meas(1'b0, 2, 0, 2, "R3 fb leads");
    meas(1'b1, 3, 0, 3, "R9 error at tight is mid");
    for (int k = 0; k < 4; k++) meas(1'b1, 0, 0, 0, "R5 run restarted");
    meas(1'b1, 0, 0, 0, "R3 simultaneous edges lock");

    // R9: loose-1 is mid, lock held
    meas(1'b1, 5, 0, 5, "R9 loose-1 holds lock");

    // R7: duplicate lead near loose; err 6 (bad), restart would give 5
    meas(1'b1, 6, 1, 6, "R7 duplicate lead ignored");

    // R7: duplicate lead, partner at 3 -> mid, restart would give good
    for (int k = 0; k < 4; k++) meas(1'b0, 1, 0, 1, "R7 setup run");
    meas(1'b0, 3, 1, 3, "R7 duplicate keeps first edge");
    meas(1'b0, 1, 0, 1, "R7 run was reset");

    // R6: timeout drops lock
    for (int k = 0; k < 5; k++) meas(1'b1, 2, 0, 2, "R6 relock");
    timeout_meas(1'b1, "R6 timeout drops lock");
    timeout_meas(1'b0, "R6 fb timeout stays unlocked");

    // R8: long quiet stretch, lock stable
    for (int k = 0; k < 5; k++) meas(1'b0, 0, 0, 0, "R8 relock");
    for (int k = 0; k < 20; k++) step(1'b0, 1'b0, 1'b0, 0, 1'b0, "R8 quiet stable");

    // R1: reset discards a partial run
    do_reset("R1 reset while locked");
    for (int k = 0; k < 4; k++) meas(1'b1, 1, 0, 1, "R1 partial run");
    do_reset("R1 reset mid run");
    meas(1'b1, 1, 0, 1, "R1 run cleared by reset");
    for (int k = 0; k < 4; k++) meas(1'b1, 1, 0, 1, "R2 lock after full run");

    repeat (4) @(negedge clk);
    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule